// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is the clocked form of a retriggerable monostable. It has three synchronous control inputs: an active-low trigger, an active-high trigger and an active-low clear. It drives a single pulse output and that output's complement. The pulse length is a cycle count taken from an input port. A pulse starts when one input makes a valid transition while the other two inputs are already at their enabling levels. Once a trigger has been accepted, a later trigger restarts the full duration, but only if it arrives far enough after the last accepted one. Clear has priority over everything and ends a pulse at once.

All three inputs are registered on the rising clock edge. Each edge is found by comparing the newest sample with the sample taken the cycle before. A control module decides when to load or clear the timer and sends those decisions as a small struct of strobes. A datapath module holds the duration counter, the counter of cycles since the last accepted trigger, and the minimum spacing derived from the programmed length.

Top module: `retrig_oneshot`

## Requirements
- R1: With clear high and the high trigger input high, a high-to-low change of the low trigger input starts a pulse. If the change is sampled at clock edge k, the output is high from edge k+1.
- R2: With clear high and the low trigger input low, a low-to-high change of the high trigger input starts a pulse, with the same latency as R1.
- R3: With the low trigger input low and the high trigger input high, a low-to-high change of clear starts a pulse, with the same latency as R1.
- R4: If clear is sampled low at edge k, the output is low from edge k and any pulse in progress is ended. Raising clear again later does not bring back the cut pulse.
- R5: The output stays high for exactly N cycles after the last accepted trigger, where N is the value on the duration port. A value of 0 is treated as 1.
- R6: A trigger that arrives during a pulse, at least S = max(1, floor(3N/10)) cycles after the previous accepted trigger, is accepted. It restarts the timing, so a retrigger D cycles after the first trigger gives a pulse D+N cycles long.
- R7: A trigger that arrives during a pulse fewer than S cycles after the previous accepted trigger is ignored. The pulse then ends N cycles after the previous accepted trigger.
- R8: During reset and after it is released, the output is low and its complement is high. Input levels that are already at trigger-ready values when reset is released produce no pulse.
- R9: Holding the low trigger input high or the high trigger input low keeps the output low. Edges on the other inputs do not start a pulse while this gating condition holds.
- R10: The complement output always equals the inverse of the pulse output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigLowN | input | 1 | Trigger that acts on its falling edge |
| trigHigh | input | 1 | Trigger that acts on its rising edge |
| clrN | input | 1 | Active-low overriding clear; its rising edge also triggers |
| durN | input | CNT_W | Pulse length in clock cycles |
| pulseOut | output | 1 | One-shot output |
| pulseOutN | output | 1 | Complement of pulseOut |

## Verification
A trigger level sampled at edge k shows at the output from edge k+1. A clear sampled at edge k shows at the output from edge k itself. Every stimulus is applied on a falling edge, and each result is read on the next falling edge, half a cycle after the register that produced it has updated. Pulse lengths are measured by counting high samples over a window that starts before the trigger and ends well after the longest expected pulse. A bench model steps at the rising edge from the same sampled inputs, and the output is compared with it on every falling edge.

// File: rtl/os_pkg.sv
package osPkg;

  // Decisions sent from control to datapath for one cycle
  typedef struct packed {
    logic load;   // accepted trigger: restart the duration
    logic clear;  // sampled clear is active: kill the pulse
  } osStrobe_t;

  // Timer state returned to control
  typedef struct packed {
    logic busy;      // pulse in progress
    logic spaceMet;  // enough cycles since last accepted trigger
  } osStatus_t;

  localparam int IN_COUNT = 3;
  localparam int IDX_A    = 0;  // active-low trigger
  localparam int IDX_B    = 1;  // active-high trigger
  localparam int IDX_C    = 2;  // active-low clear

endpackage

// File: rtl/os_control.sv
module osControl
  import osPkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trigLowN,
  input  logic      trigHigh,
  input  logic      clrN,
  input  osStatus_t status,
  output osStrobe_t strobe
);

  // Idle-looking reset values; edges are ignored until two real samples exist
  localparam logic [IN_COUNT-1:0] IDLE_LVL = 3'b101;

  logic [IN_COUNT-1:0] rawIn;
  logic [IN_COUNT-1:0] curSmp;
  logic [IN_COUNT-1:0] prevSmp;
  logic [1:0]          primed;

  assign rawIn = {clrN, trigHigh, trigLowN};

  genvar gi;
  generate
    for (gi = 0; gi < IN_COUNT; gi++) begin : g_smp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          curSmp[gi]  <= IDLE_LVL[gi];
          prevSmp[gi] <= IDLE_LVL[gi];
        end else begin
          curSmp[gi]  <= rawIn[gi];
          prevSmp[gi] <= curSmp[gi];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 2'b00;
    else        primed <= {primed[0], 1'b1};
  end

  logic aFall, bRise, cRise;
  logic aArm, bArm, cArm;
  logic fireRaw, fire;

  always_comb begin
    aFall = prevSmp[IDX_A] & ~curSmp[IDX_A];
    bRise = ~prevSmp[IDX_B] & curSmp[IDX_B];
    cRise = ~prevSmp[IDX_C] & curSmp[IDX_C];
    aArm  = ~curSmp[IDX_A];
    bArm  = curSmp[IDX_B];
    cArm  = curSmp[IDX_C];
    fireRaw = (aFall & bArm) | (bRise & aArm) | (cRise & aArm & bArm);
    fire    = primed[1] & cArm & fireRaw;
  end

  always_comb begin
    strobe.clear = ~curSmp[IDX_C];
    strobe.load  = fire & (~status.busy | status.spaceMet);
  end

endmodule

// File: rtl/os_datapath.sv
module osDatapath
  import osPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] durN,
  input  osStrobe_t        strobe,
  output osStatus_t        status,
  output logic             pulseOut,
  output logic             pulseOutN
);

  localparam int PW = CNT_W + 2;
  localparam logic [CNT_W-1:0] AGE_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] effDur;
  logic [PW-1:0]    triple;
  logic [PW-1:0]    tenth;
  logic [CNT_W-1:0] minSpace;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] age;
  logic             busy;

  // Length of 0 behaves as 1; spacing is 30% of length, at least one cycle
  always_comb begin
    effDur   = (durN == '0) ? CNT_W'(1) : durN;
    triple   = PW'(effDur) * PW'(3);
    tenth    = triple / PW'(10);
    minSpace = (tenth == '0) ? CNT_W'(1) : CNT_W'(tenth);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (strobe.clear) begin
      remain <= '0;
    end else if (strobe.load) begin
      remain <= effDur;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0;
    end else if (strobe.load) begin
      age <= CNT_W'(1);
    end else if (age != AGE_MAX) begin
      age <= age + 1'b1;
    end
  end

  assign busy            = (remain != '0);
  assign status.busy     = busy;
  assign status.spaceMet = (age >= minSpace);

  // Sampled clear masks the output in the same cycle it is seen
  assign pulseOut  = busy & ~strobe.clear;
  assign pulseOutN = ~pulseOut;

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import osPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigLowN,
  input  logic             trigHigh,
  input  logic             clrN,
  input  logic [CNT_W-1:0] durN,
  output logic             pulseOut,
  output logic             pulseOutN
);

  osStrobe_t ctlStrobe;
  osStatus_t dpStatus;

  osControl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .trigLowN (trigLowN),
    .trigHigh (trigHigh),
    .clrN     (clrN),
    .status   (dpStatus),
    .strobe   (ctlStrobe)
  );

  osDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .durN      (durN),
    .strobe    (ctlStrobe),
    .status    (dpStatus),
    .pulseOut  (pulseOut),
    .pulseOutN (pulseOutN)
  );

endmodule

// File: rtl/retrig_oneshot_chk.sv
module retrig_oneshot_chk (
  input logic clk,
  input logic rst_n,
  input logic clrN,
  input logic loadStb,
  input logic pulseOut,
  input logic pulseOutN
);

  // R10: outputs are complementary
  assert_complement_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pulseOutN == !pulseOut);

  // R4: a sampled clear forces the output low from that edge
  assert_clear_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clrN |=> !pulseOut);

  // R1: an accepted trigger with clear still high yields a high output
  assert_load_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (loadStb && clrN) |=> pulseOut);

  // R9: the output never rises without an accepted trigger just before
  assert_rise_needs_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulseOut) |-> $past(loadStb));

endmodule

bind retrig_oneshot retrig_oneshot_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clrN      (clrN),
  .loadStb   (ctlStrobe.load),
  .pulseOut  (pulseOut),
  .pulseOutN (pulseOutN)
);

// File: tb/retrig_oneshot_tb.sv
`timescale 1ns/1ps
module retrig_oneshot_tb;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             inA = 1'b0;
  logic             inB = 1'b1;
  logic             inC = 1'b1;
  logic [CNT_W-1:0] durN = 16'd10;
  logic             pulseOut;
  logic             pulseOutN;

  int errors = 0;
  int checks = 0;
  int hiCnt = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit cycleCheck = 1'b0;
  string curTag = "R8";

  always #2 clk = ~clk;  // 250 MHz

  retrig_oneshot #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .trigLowN(inA), .trigHigh(inB), .clrN(inC),
    .durN(durN), .pulseOut(pulseOut), .pulseOutN(pulseOutN)
  );

  // ---------------- reference model from the requirements ----------------
  logic [2:0] mCur, mPrev;
  bit mP1, mP2;
  int mRem, mAge;

  function automatic int spacingOf(input int n);
    int e, s;
    e = (n == 0) ? 1 : n;
    s = (3 * e) / 10;
    return (s < 1) ? 1 : s;
  endfunction

  function automatic bit modelFire(input logic [2:0] cur, input logic [2:0] prev);
    bit aFall, bRise, cRise;
    aFall = prev[0] && !cur[0] && cur[1];
    bRise = !prev[1] && cur[1] && !cur[0];
    cRise = !prev[2] && cur[2] && !cur[0] && cur[1];
    return cur[2] && (aFall || bRise || cRise);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCur = 3'b101; mPrev = 3'b101; mP1 = 0; mP2 = 0; mRem = 0; mAge = 0;
    end else begin
      int eff;
      bit busy, acc;
      eff  = (durN == 0) ? 1 : int'(durN);
      busy = (mRem != 0);
      acc  = mP2 && modelFire(mCur, mPrev) && (!busy || mAge >= spacingOf(int'(durN)));
      if (!mCur[2]) mRem = 0;
      else if (acc) mRem = eff;
      else if (busy) mRem = mRem - 1;
      if (acc) mAge = 1;
      else if (mAge < 65535) mAge = mAge + 1;
      mPrev = mCur;
      mCur  = {inC, inB, inA};
      mP2 = mP1; mP1 = 1;
    end
  end

  function automatic bit expQ();
    return (mRem != 0) && mCur[2];
  endfunction

  // ---------------- checking ----------------
  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cycleCheck && rst_n && !done) begin
      checkEq(curTag, int'(pulseOut), int'(expQ()));
      checkEq("R10", int'(pulseOutN), int'(!pulseOut));
    end
  end

  task automatic tick(input logic a, input logic b, input logic c);
    @(negedge clk);
    if (pulseOut) hiCnt++;
    inA = a; inB = b; inC = c;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) tick(inA, inB, inC);
  endtask

  // D-cycle retrigger on the high trigger input, starting from B low, A low
  task automatic bPair(input int d);
    tick(0, 0, 1); tick(0, 0, 1);
    hiCnt = 0;
    tick(0, 1, 1);
    for (int i = 1; i < d; i++) tick(0, 0, 1);
    tick(0, 1, 1);
    hold(durN + d + 10);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd97531);

    // R8: reset with trigger-ready levels (A low, B high, clear high)
    repeat (4) @(negedge clk);
    checkEq("R8", int'(pulseOut), 0);
    checkEq("R8", int'(pulseOutN), 1);
    rst_n = 1'b1;
    cycleCheck = 1'b1;
    hiCnt = 0;
    hold(20);
    checkEq("R8", hiCnt, 0);

    // R1: falling A with B high
    curTag = "R1";
    tick(1, 1, 1); tick(1, 1, 1);
    hiCnt = 0;
    tick(0, 1, 1); hold(25);
    checkEq("R1", hiCnt, 10);

    // R2: rising B with A low
    curTag = "R2";
    tick(0, 0, 1); tick(0, 0, 1);
    hiCnt = 0;
    tick(0, 1, 1); hold(25);
    checkEq("R2", hiCnt, 10);

    // R3: clear released with A low, B high
    curTag = "R3";
    tick(0, 1, 0); tick(0, 1, 0); tick(0, 1, 0);
    hiCnt = 0;
    tick(0, 1, 1); hold(25);
    checkEq("R3", hiCnt, 10);

    // R4: clear cuts the pulse after 3 high cycles; no resumption
    curTag = "R4";
    tick(0, 0, 1); tick(0, 0, 1);
    hiCnt = 0;
    tick(0, 1, 1); hold(3);
    tick(0, 0, 0); tick(0, 0, 0);
    tick(0, 0, 1); hold(20);
    checkEq("R4", hiCnt, 3);

    // R6: retrigger at 5 cycles, N=10 (S=3) -> 15
    curTag = "R6";
    bPair(5);
    checkEq("R6", hiCnt, 15);
    // R6: boundary, spacing exactly S=3 -> 13
    bPair(3);
    checkEq("R6", hiCnt, 13);

    // R7: spacing 2 < S -> ignored, 10
    curTag = "R7";
    bPair(2);
    checkEq("R7", hiCnt, 10);
    // R7 via the low trigger: A fall, rise, fall 2 cycles apart
    tick(1, 1, 1); tick(1, 1, 1);
    hiCnt = 0;
    tick(0, 1, 1); tick(1, 1, 1); tick(0, 1, 1); hold(25);
    checkEq("R7", hiCnt, 10);

    // R9: gated edges produce nothing
    curTag = "R9";
    hiCnt = 0;
    tick(1, 0, 1); tick(0, 0, 1); tick(1, 0, 1); tick(0, 0, 1);
    tick(1, 0, 1); tick(1, 1, 1); tick(1, 0, 1); tick(1, 1, 1);
    tick(1, 1, 0); tick(1, 1, 1); hold(20);
    checkEq("R9", hiCnt, 0);

    // R5: lengths 1, 0 and 37; S(37)=11 boundary on both sides
    curTag = "R5";
    durN = 16'd1;
    bPair(1);
    checkEq("R5", hiCnt, 1);
    durN = 16'd0;
    tick(0, 0, 1); tick(0, 0, 1);
    hiCnt = 0;
    tick(0, 1, 1); hold(10);
    checkEq("R5", hiCnt, 1);
    durN = 16'd37;
    tick(0, 0, 1); tick(0, 0, 1);
    hiCnt = 0;
    tick(0, 1, 1); hold(50);
    checkEq("R5", hiCnt, 37);
    curTag = "R7";
    bPair(10);
    checkEq("R7", hiCnt, 37);
    curTag = "R6";
    bPair(11);
    checkEq("R6", hiCnt, 48);

    // Random phase against the model
    curTag = "R5";
    for (int i = 0; i < 6000; i++) begin
      logic na, nb, nc;
      na = ($urandom % 6 == 0) ? !inA : inA;
      nb = ($urandom % 6 == 0) ? !inB : inB;
      nc = ($urandom % 25 == 0) ? !inC : inC;
      if (!inC && ($urandom % 3 == 0)) nc = 1'b1;
      if (i % 300 == 0) durN = CNT_W'(1 + ($urandom % 24));
      tick(na, nb, nc);
    end

    hold(40);
    cycleCheck = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule